// File: doc/BRIEF.md
# Pop-Free Audio Mode Sequencer

This block sits on the host side of an audio codec that is configured through a three-wire serial port: a frame select, a serial clock and a data line. It takes a mode request and runs a fixed script for that mode. The script is a series of serial control writes with timed pauses between them, plus changes to a standby line. The amplifiers are powered and unmuted in an order that keeps clicks and pops off the speaker and the line output.

Five scripts are built in:
- playback start-up;
- record start-up;
- a change from record to speaker playback with a chosen volume;
- a change from line playback to record;
- a shutdown that restores the default word and then puts the codec back into standby.

Every pause is a parameter given in milliseconds. It is counted on a timebase of `CLK_PER_MS` clock cycles. The block also does the serial shifting itself.

Top module: `audio_mode_seq`

## Requirements
- R1: After reset `busy_o` is 0, `standby_o` is 1, and `ser_cs_o` and `ser_clk_o` are both 0.
- R2: A control write is one frame. `ser_cs_o` is high for the whole frame and `ser_clk_o` gives 16 rising edges inside it. The 16-bit word goes out least-significant bit first. `ser_dat_o` is stable while `ser_clk_o` is high, and `ser_clk_o` is only ever high inside a frame.
- R3: A dummy transfer is a `ser_cs_o` pulse with no `ser_clk_o` edge in it.
- R4: Mode 0 (playback start-up) runs the following steps in order:
  - release standby (`standby_o` goes to 0);
  - send a dummy transfer;
  - write 0x059E, which puts the charge circuit off (bit 2 = 1), the speaker off (bit 10 = 1) and the line off (bit 8 = 1);
  - write 0x019E, which turns the speaker on (bit 10 = 0);
  - write 0x049E, which turns the line on (bit 8 = 0).
- R5: Mode 1 (record start-up) runs the following steps in order:
  - release standby;
  - send a dummy transfer;
  - write 0x0536 (charge circuit off, ALC off with bit 4 = 1, filter in record mode with bit 5 = 1);
  - write 0x0526, which turns the ALC on.
- R6: Mode 2 (record to speaker) writes the following three words in order; `VOL` is `vol_i` placed in bits 15:11:
  - 0x0526, with the speaker off;
  - 0x059E | `VOL`, in playback mode with the speaker still off;
  - 0x019E | `VOL`, with the speaker on, sent at least `W_SPKSW_MS` ms after the previous frame ends.
- R7: Mode 3 (line playback to record) writes 0x059E and then 0x0526. The second frame starts at least `W_LINESW_MS` ms after the first one ends.
- R8: Mode 4 (shutdown) writes the default word 0x0502 (bits 1, 8 and 10 set). `standby_o` returns to 1 at least `W_OFF_MS` ms after that frame ends.
- R9: Each script pause lasts at least its parameter times `CLK_PER_MS` cycles. For example, in mode 0 the dummy transfer starts at least `W_REL_MS` ms after standby is released, and the 0x019E frame starts at least `W_CHG_MS` ms after the 0x059E frame ends.
- R10: `busy_o` rises on the edge after an accepted request and stays high until the script ends. A request made while busy has no effect, and neither does a request with a mode code of 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse; sampled when idle |
| mode_i | input | 3 | Script code 0..4 |
| vol_i | input | 5 | Volume used by mode 2 |
| busy_o | output | 1 | Script in progress |
| standby_o | output | 1 | Codec standby, 1 = standby |
| ser_cs_o | output | 1 | Serial frame select, active high |
| ser_clk_o | output | 1 | Serial clock |
| ser_dat_o | output | 1 | Serial data, LSB first |

## Verification
The assertions assume that `mode_i` and `vol_i` are valid in the cycle `req_i` is high. They also assume `req_i` is a synchronous pulse, so the only thing that can change the script state is the idle-state decode. The bench drives all inputs on the falling clock edge and holds mode and volume steady around each request. Its monitor rebuilds frames from the serial pins alone, which lets it check frame contents, dummy pulses and the pauses between frames without looking inside the design. Requests made while busy, and requests with mode codes above 4, are applied deliberately so that an unwanted frame or a busy pulse would show up at the pins.

// File: rtl/audseq_pkg.sv
package audseq_pkg;
  typedef enum logic [2:0] {
    OP_END, OP_STBY_REL, OP_STBY_SET, OP_DUMMY, OP_WORD, OP_WAIT
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [15:0] arg;
  } step_t;

  localparam logic [2:0] MODE_PB_UP  = 3'd0;
  localparam logic [2:0] MODE_REC_UP = 3'd1;
  localparam logic [2:0] MODE_TO_SPK = 3'd2;
  localparam logic [2:0] MODE_TO_REC = 3'd3;
  localparam logic [2:0] MODE_SHUT   = 3'd4;
  localparam logic [2:0] NUM_MODES   = 3'd5;

  // control words: bit2 charge off, bit4 ALC off, bit5 record filter,
  // bit8 line off, bit10 speaker off, bits 15:11 volume
  localparam logic [15:0] W_DEFAULT    = 16'h0502;
  localparam logic [15:0] W_PB_QUIET   = 16'h059E;
  localparam logic [15:0] W_PB_SPK     = 16'h019E;
  localparam logic [15:0] W_PB_LINE    = 16'h049E;
  localparam logic [15:0] W_REC_ALCOFF = 16'h0536;
  localparam logic [15:0] W_REC_RUN    = 16'h0526;

  function automatic step_t mk(op_e op, logic [15:0] arg);
    step_t s;
    s.op  = op;
    s.arg = arg;
    return s;
  endfunction
endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int CLK_PER_MS = 250000,
  parameter int MS_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expired_o
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [MS_W-1:0]  ms_q, ms_d;
  logic             run_q, run_d;

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    run_d = run_q;
    if (load_i) begin
      pre_d = '0;
      ms_d  = ms_i;
      run_d = (ms_i != '0);
    end else if (run_q) begin
      if (pre_q == PRE_LAST) begin
        pre_d = '0;
        ms_d  = ms_q - 1'b1;
        if (ms_q == MS_W'(1)) run_d = 1'b0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
      run_q <= run_d;
    end
  end

  assign expired_o = !run_q;

  // a pause only begins on a load request
  assert_wait_starts_on_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expired_o) |-> $past(load_i));
  // a running pause never wraps its millisecond count
  assert_no_ms_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !load_i) |=> (ms_q <= $past(ms_q)));
endmodule

// File: rtl/seq_serial_tx.sv
module seq_serial_tx #(
  parameter int HALF   = 100,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dummy_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              done_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(WORD_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LO, S_HI, S_HOLD, S_GAP} st_e;

  st_e              st_q, st_d;
  logic [HW-1:0]    hc_q, hc_d;
  logic [BW-1:0]    bc_q, bc_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic             dmy_q, dmy_d;
  logic             adv;

  assign adv = (hc_q == H_LAST);

  always_comb begin
    st_d  = st_q;
    hc_d  = hc_q;
    bc_d  = bc_q;
    sh_d  = sh_q;
    dmy_d = dmy_q;
    if (st_q == S_IDLE) begin
      if (start_i) begin
        st_d  = S_SETUP;
        hc_d  = '0;
        bc_d  = '0;
        sh_d  = word_i;
        dmy_d = dummy_i;
      end
    end else begin
      hc_d = adv ? '0 : hc_q + 1'b1;
      if (adv) begin
        unique case (st_q)
          S_SETUP: st_d = dmy_q ? S_HOLD : S_LO;
          S_LO:    st_d = S_HI;
          S_HI: begin
            sh_d = sh_q >> 1;
            bc_d = bc_q + 1'b1;
            st_d = (bc_q == B_LAST) ? S_HOLD : S_LO;
          end
          S_HOLD:  st_d = S_GAP;
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      hc_q  <= '0;
      bc_q  <= '0;
      sh_q  <= '0;
      dmy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hc_q  <= hc_d;
      bc_q  <= bc_d;
      sh_q  <= sh_d;
      dmy_q <= dmy_d;
    end
  end

  assign cs_o   = (st_q == S_SETUP) || (st_q == S_LO) || (st_q == S_HI) || (st_q == S_HOLD);
  assign sclk_o = (st_q == S_HI);
  assign sdat_o = cs_o & sh_q[0];
  assign done_o = (st_q == S_GAP) && adv;

  assert_clk_inside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> cs_o);
  assert_data_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));
  assert_dummy_no_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dmy_q && cs_o) |-> !sclk_o);
endmodule

// File: rtl/audio_mode_seq.sv
module audio_mode_seq
  import audseq_pkg::*;
#(
  parameter int CLK_PER_MS  = 250000,
  parameter int SCLK_HALF   = 100,
  parameter int W_REL_MS    = 10,
  parameter int W_DUMMY_MS  = 20,
  parameter int W_CHG_MS    = 50,
  parameter int W_SPK_MS    = 150,
  parameter int W_ALC_MS    = 30,
  parameter int W_SPKSW_MS  = 20,
  parameter int W_LINESW_MS = 5,
  parameter int W_OFF_MS    = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [2:0] mode_i,
  input  logic [4:0] vol_i,
  output logic       busy_o,
  output logic       standby_o,
  output logic       ser_cs_o,
  output logic       ser_clk_o,
  output logic       ser_dat_o
);
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {T_IDLE, T_EXEC, T_SER, T_TMR} tst_e;

  logic [1:0] sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  function automatic step_t script(logic [2:0] m, logic [3:0] pc, logic [4:0] vol);
    logic [15:0] vw;
    step_t s;
    vw = {vol, 11'b0};
    s  = mk(OP_END, 16'h0);
    unique case (m)
      MODE_PB_UP, MODE_REC_UP: begin
        unique case (pc)
          4'd0: s = mk(OP_STBY_REL, 16'h0);
          4'd1: s = mk(OP_WAIT, 16'(W_REL_MS));
          4'd2: s = mk(OP_DUMMY, 16'h0);
          4'd3: s = mk(OP_WAIT, 16'(W_DUMMY_MS));
          4'd4: s = mk(OP_WORD, (m == MODE_PB_UP) ? W_PB_QUIET : W_REC_ALCOFF);
          4'd5: s = mk(OP_WAIT, (m == MODE_PB_UP) ? 16'(W_CHG_MS) : 16'(W_ALC_MS));
          4'd6: s = mk(OP_WORD, (m == MODE_PB_UP) ? W_PB_SPK : W_REC_RUN);
          4'd7: s = (m == MODE_PB_UP) ? mk(OP_WAIT, 16'(W_SPK_MS)) : mk(OP_END, 16'h0);
          4'd8: s = (m == MODE_PB_UP) ? mk(OP_WORD, W_PB_LINE) : mk(OP_END, 16'h0);
          default: s = mk(OP_END, 16'h0);
        endcase
      end
      MODE_TO_SPK: begin
        unique case (pc)
          4'd0: s = mk(OP_WORD, W_REC_RUN);
          4'd1: s = mk(OP_WAIT, 16'(W_SPKSW_MS));
          4'd2: s = mk(OP_WORD, W_PB_QUIET | vw);
          4'd3: s = mk(OP_WAIT, 16'(W_SPKSW_MS));
          4'd4: s = mk(OP_WORD, W_PB_SPK | vw);
          default: s = mk(OP_END, 16'h0);
        endcase
      end
      MODE_TO_REC: begin
        unique case (pc)
          4'd0: s = mk(OP_WORD, W_PB_QUIET);
          4'd1: s = mk(OP_WAIT, 16'(W_LINESW_MS));
          4'd2: s = mk(OP_WORD, W_REC_RUN);
          default: s = mk(OP_END, 16'h0);
        endcase
      end
      MODE_SHUT: begin
        unique case (pc)
          4'd0: s = mk(OP_WORD, W_DEFAULT);
          4'd1: s = mk(OP_WAIT, 16'(W_OFF_MS));
          4'd2: s = mk(OP_STBY_SET, 16'h0);
          default: s = mk(OP_END, 16'h0);
        endcase
      end
      default: s = mk(OP_END, 16'h0);
    endcase
    return s;
  endfunction

  tst_e       st_q, st_d;
  logic [3:0] pc_q, pc_d;
  logic [2:0] mode_q;
  logic [4:0] vol_q;
  logic       stby_q, stby_d;
  logic       cfg_en;
  logic       ser_start, ser_done, tmr_load, tmr_exp;
  step_t      cur;

  assign cur = script(mode_q, pc_q, vol_q);

  always_comb begin
    st_d      = st_q;
    pc_d      = pc_q;
    stby_d    = stby_q;
    cfg_en    = 1'b0;
    ser_start = 1'b0;
    tmr_load  = 1'b0;
    unique case (st_q)
      T_IDLE: begin
        if (req_i && (mode_i < NUM_MODES)) begin
          cfg_en = 1'b1;
          pc_d   = '0;
          st_d   = T_EXEC;
        end
      end
      T_EXEC: begin
        unique case (cur.op)
          OP_STBY_REL: begin stby_d = 1'b0; pc_d = pc_q + 1'b1; end
          OP_STBY_SET: begin stby_d = 1'b1; pc_d = pc_q + 1'b1; end
          OP_DUMMY, OP_WORD: begin ser_start = 1'b1; st_d = T_SER; end
          OP_WAIT: begin tmr_load = 1'b1; st_d = T_TMR; end
          default: st_d = T_IDLE;
        endcase
      end
      T_SER: if (ser_done) begin pc_d = pc_q + 1'b1; st_d = T_EXEC; end
      default: if (tmr_exp) begin pc_d = pc_q + 1'b1; st_d = T_EXEC; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= T_IDLE;
      pc_q   <= '0;
      stby_q <= 1'b1;
      mode_q <= '0;
      vol_q  <= '0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      stby_q <= stby_d;
      if (cfg_en) begin
        mode_q <= mode_i;
        vol_q  <= vol_i;
      end
    end
  end

  seq_wait_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(16)) u_tmr (
    .clk(clk), .rst_n(rst_s), .load_i(tmr_load), .ms_i(cur.arg), .expired_o(tmr_exp)
  );

  seq_serial_tx #(.HALF(SCLK_HALF), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_s), .start_i(ser_start), .dummy_i(cur.op == OP_DUMMY),
    .word_i(cur.arg), .cs_o(ser_cs_o), .sclk_o(ser_clk_o), .sdat_o(ser_dat_o),
    .done_o(ser_done)
  );

  assign busy_o    = (st_q != T_IDLE);
  assign standby_o = stby_q;

  assert_frame_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_s)
    ser_cs_o |-> busy_o);
  assert_busy_req_ignored_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_o && req_i) |=> ($stable(mode_q) && $stable(vol_q)));
  assert_standby_moves_in_script_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !$stable(standby_o) |-> $past(busy_o));
  assert_no_start_when_frame_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ser_start |-> !ser_cs_o);
endmodule

// File: tb/sim_audio_mode_seq.sv
module sim_audio_mode_seq;
  localparam int CPM  = 4;
  localparam int HALF = 2;
  localparam int WREL = 10, WCHG = 50, WSPKSW = 20, WLINESW = 5, WOFF = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [2:0] mode = '0;
  logic [4:0] vol = '0;
  logic busy, stby, cs, sclk, sdat;

  always #2 clk = ~clk;

  audio_mode_seq #(.CLK_PER_MS(CPM), .SCLK_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .vol_i(vol),
    .busy_o(busy), .standby_o(stby), .ser_cs_o(cs), .ser_clk_o(sclk), .ser_dat_o(sdat)
  );

  int checks = 0, errors = 0, cyc = 0;
  int nfr = 0;
  int fr_bits[8], fr_start[8], fr_end[8];
  logic [15:0] fr_word[8];
  logic [15:0] cur_w;
  int cur_b, stby_fall, stby_rise;
  bit done_flag = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1;
      errors++;
      $display("FAIL watchdog: act cycle %0d exp < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge cs) begin cur_w = '0; cur_b = 0; if (nfr < 8) fr_start[nfr] = cyc; end
  always @(posedge sclk) if (cs) begin cur_w = {sdat, cur_w[15:1]}; cur_b++; end
  always @(negedge cs) if (nfr < 8) begin
    fr_word[nfr] = cur_w; fr_bits[nfr] = cur_b; fr_end[nfr] = cyc; nfr++;
  end
  always @(negedge stby) stby_fall = cyc;
  always @(posedge stby) stby_rise = cyc;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [4:0] v);
    nfr = 0;
    @(negedge clk);
    req = 1'b1; mode = m; vol = v;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R10 busy after request", busy, 1);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // mode, vol, frames, dummy first, four frame words
  localparam logic [75:0] VEC [5] = '{
    {3'd0, 5'd0,  3'd4, 1'b1, 16'h0000, 16'h059E, 16'h019E, 16'h049E},
    {3'd3, 5'd0,  3'd2, 1'b0, 16'h059E, 16'h0526, 16'h0000, 16'h0000},
    {3'd2, 5'd17, 3'd3, 1'b0, 16'h0526, 16'h8D9E, 16'h899E, 16'h0000},
    {3'd1, 5'd0,  3'd3, 1'b1, 16'h0000, 16'h0536, 16'h0526, 16'h0000},
    {3'd4, 5'd0,  3'd1, 1'b0, 16'h0502, 16'h0000, 16'h0000, 16'h0000}
  };

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && stby == 1 && cs == 0 && sclk == 0, "R1 in reset", {busy, stby, cs, sclk}, 4'b0100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && stby == 1 && cs == 0 && sclk == 0, "R1 after reset", {busy, stby, cs, sclk}, 4'b0100);

    for (int i = 0; i < 5; i++) begin
      logic [2:0] m;
      int n;
      string t;
      m = VEC[i][75:73];
      n = int'(VEC[i][67:65]);
      t = tag_of(m);
      run(m, VEC[i][72:68]);
      chk(nfr == n, {t, " frame count"}, nfr, n);
      for (int k = 0; k < 4; k++) begin
        if (k < n) begin
          logic [15:0] ew;
          ew = VEC[i][63 - 16*k -: 16];
          if (VEC[i][64] && k == 0)
            chk(fr_bits[0] == 0, "R3 dummy has no clocks", fr_bits[0], 0);
          else begin
            chk(fr_bits[k] == 16, "R2 sixteen clocks", fr_bits[k], 16);
            chk(fr_word[k] == ew, {t, " word LSB first"}, fr_word[k], ew);
          end
        end
      end
      case (m)
        3'd0: begin
          chk(stby == 0, "R4 standby released", stby, 0);
          chk(fr_start[0] - stby_fall >= WREL*CPM, "R9 release pause", fr_start[0] - stby_fall, WREL*CPM);
          chk(fr_start[2] - fr_end[1] >= WCHG*CPM, "R9 charge pause", fr_start[2] - fr_end[1], WCHG*CPM);
        end
        3'd2: chk(fr_start[2] - fr_end[1] >= WSPKSW*CPM, "R6 speaker on delay", fr_start[2] - fr_end[1], WSPKSW*CPM);
        3'd3: chk(fr_start[1] - fr_end[0] >= WLINESW*CPM, "R7 switch delay", fr_start[1] - fr_end[0], WLINESW*CPM);
        3'd4: begin
          chk(stby == 1, "R8 standby set", stby, 1);
          chk(stby_rise - fr_end[0] >= WOFF*CPM, "R8 standby delay", stby_rise - fr_end[0], WOFF*CPM);
        end
        default: ;
      endcase
    end

    // request while busy: shutdown must not run inside a mode 3 script
    nfr = 0;
    @(negedge clk); req = 1'b1; mode = 3'd3; vol = '0;
    @(negedge clk); req = 1'b0;
    repeat (20) @(negedge clk);
    req = 1'b1; mode = 3'd4;
    @(negedge clk); req = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(nfr == 2, "R10 busy request ignored count", nfr, 2);
    chk(fr_word[1] == 16'h0526, "R10 busy request ignored word", fr_word[1], 16'h0526);
    chk(stby == 1, "R10 standby untouched", stby, 1);

    // invalid mode codes
    for (int c = 5; c < 8; c++) begin
      nfr = 0;
      @(negedge clk); req = 1'b1; mode = 3'(c);
      @(negedge clk); req = 1'b0;
      chk(busy == 0, "R10 invalid mode busy", busy, 0);
      repeat (50) @(negedge clk);
      chk(nfr == 0, "R10 invalid mode no frame", nfr, 0);
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule